// File: doc/BRIEF.md
# Burst Address Sequence Monitor

This block is a passive observer that sits beside a pipelined bus address phase and checks that every beat of a burst carries the address implied by how the burst began. It watches the transfer kind, address, burst kind, beat size and ready signal. When it sees a first beat, it records the start address, burst kind and beat size. From then on, it works out on its own where each following beat must land. It handles linear bursts and bursts that wrap inside a naturally aligned block, and it never assumes the sequence only rises.

The monitor raises a one-cycle pulse for each beat that breaks the rules. It also keeps a flag that stays set once any such beat has been seen. The expected and observed addresses of the very first failing beat are frozen on two output buses until the next reset. The block drives nothing onto the bus. It ignores data, responses and every timing rule other than address sequencing.

Its control is a three-state machine. MON_IDLE means no burst is open. MON_BURST means a burst is open and more beats may follow. MON_END means a fixed-length burst has delivered all its beats. The transitions are named as follows. START: a sampled first beat, from any state, goes to MON_END for a single transfer and to MON_BURST for everything else. LAST: the final sequential beat of a fixed-length burst goes from MON_BURST to MON_END. STOP: a sampled idle transfer, from any state, goes to MON_IDLE. HOLD: a busy transfer, an unsampled cycle or an ordinary sequential beat leaves the state where it is.

Top module: `burst_addr_monitor`

## Requirements
- R1: The transfer kind `bus_trans` is encoded as 0 idle, 1 busy, 2 first beat (non-sequential) and 3 sequential. The beat size is 2^`bus_size` bytes. The burst kind `bus_burst` is encoded as 0 single, 1 open-ended linear, 2/4/6 wrapping over 4/8/16 beats, and 3/5/7 linear over 4/8/16 beats. For a linear burst, beat n must be at start + n × size. This holds across any block boundary, and without limit for the open-ended kind.
- R2: For a wrapping burst, let the span be the beat count × the beat size. Beat n must be at (start with its low log2(span) bits cleared) ORed with ((start + n × size) mod span). The resulting sequence that falls back to a lower address is accepted. For example, 16 words from 0x3038 must run 0x3038, 0x303C, 0x3000, 0x3004 and on up to 0x3034.
- R3: A sequential beat whose address differs from the prediction causes `mismatch_pulse` to be high for exactly the one cycle after the clock edge that sampled it. This covers a wrapping burst that runs past its block, and one that stays in a block but with the wrong base. A first beat never causes a pulse.
- R4: A beat is sampled only on a clock edge where `bus_ready` is 1. A busy transfer neither advances nor disturbs the prediction. An idle transfer closes the open burst.
- R5: A sequential beat whose burst kind or beat size differs from the values captured on the first beat is flagged like an address mismatch.
- R6: These sequential beats are also flagged: a beat after the last beat of a fixed-length burst (including after a single transfer), and a beat when no burst is open.
- R7: `err_sticky` rises together with the first pulse and stays 1 until reset. `first_exp_addr` and `first_obs_addr` take the expected and observed address of the first flagged beat and are not changed by later flagged beats.
- R8: After reset, `mismatch_pulse` and `err_sticky` are 0, both address outputs are 0, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_trans | input | 2 | Observed transfer kind |
| bus_addr | input | AW | Observed address |
| bus_burst | input | 3 | Observed burst kind |
| bus_size | input | 3 | Observed beat size, log2 of bytes |
| bus_ready | input | 1 | Beat is sampled when 1 |
| mismatch_pulse | output | 1 | One-cycle pulse per flagged beat |
| err_sticky | output | 1 | Set on first flagged beat, held until reset |
| first_exp_addr | output | AW | Expected address of first flagged beat |
| first_obs_addr | output | AW | Observed address of first flagged beat |

## Verification
A wrong beat counter or a wrong captured base inside the monitor makes the prediction drift. It shows up as a false `mismatch_pulse` one cycle after the first sequential beat that is affected. The bench therefore runs legal bursts of every kind, several beat sizes and several start offsets, and expects silence on every beat. A state machine stuck in the wrong state shows up the same way. It either flags a legal beat or misses the beat after a completed fixed burst or after an idle. The frozen address pair then shows whether the base or the offset was the part that went wrong.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_t;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_BURST = 2'd1,
        MON_END   = 2'd2
    } mon_state_t;

    typedef struct packed {
        logic       wrap;    // offset stays inside the aligned span
        logic       fixed;   // beat count is known
        logic [2:0] len_lg;  // log2 of the beat count
    } burst_info_t;

    function automatic burst_info_t decode_burst(input logic [2:0] kind);
        burst_info_t info;
        info.wrap   = (kind >= 3'd2) && !kind[0];
        info.fixed  = (kind != 3'd1);
        info.len_lg = (kind >= 3'd2) ? ({1'b0, kind[2:1]} + 3'd1) : 3'd0;
        return info;
    endfunction

endpackage

// File: rtl/bmon_predict.sv
module bmon_predict #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] start_addr,
    input  logic [2:0]    size_lg,
    input  logic [2:0]    len_lg,
    input  logic          wrap,
    input  logic [AW-1:0] beat_idx,
    output logic [AW-1:0] exp_addr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] linear;
    logic [3:0]    span_lg;
    logic [AW-1:0] span_mask;

    always_comb begin
        linear    = start_addr + (beat_idx << size_lg);
        span_lg   = {1'b0, len_lg} + {1'b0, size_lg};
        span_mask = (ONE << span_lg) - ONE;
        if (wrap) exp_addr = (start_addr & ~span_mask) | (linear & span_mask);
        else      exp_addr = linear;
    end
endmodule

// File: rtl/bmon_err_latch.sv
module bmon_err_latch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flag,
    input  logic [AW-1:0] exp_addr,
    input  logic [AW-1:0] obs_addr,
    output logic          pulse,
    output logic          sticky,
    output logic [AW-1:0] first_exp,
    output logic [AW-1:0] first_obs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse     <= 1'b0;
            sticky    <= 1'b0;
            first_exp <= '0;
            first_obs <= '0;
        end else begin
            pulse <= flag;
            if (flag) sticky <= 1'b1;
            if (flag && !sticky) begin
                first_exp <= exp_addr;
                first_obs <= obs_addr;
            end
        end
    end
endmodule

// File: rtl/burst_addr_monitor.sv
module burst_addr_monitor
    import bmon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_trans,
    input  logic [AW-1:0] bus_addr,
    input  logic [2:0]    bus_burst,
    input  logic [2:0]    bus_size,
    input  logic          bus_ready,
    output logic          mismatch_pulse,
    output logic          err_sticky,
    output logic [AW-1:0] first_exp_addr,
    output logic [AW-1:0] first_obs_addr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    mon_state_t    state_q, state_d;
    logic [AW-1:0] cap_start;
    logic [2:0]    cap_burst;
    logic [2:0]    cap_size;
    logic [AW-1:0] beat_cnt;
    burst_info_t   cap_info, new_info;
    logic [AW-1:0] exp_addr;
    logic [AW-1:0] last_idx;
    logic          flag, load, adv;

    assign cap_info = decode_burst(cap_burst);
    assign new_info = decode_burst(bus_burst);
    assign last_idx = (ONE << cap_info.len_lg) - ONE;

    bmon_predict #(.AW(AW)) u_predict (
        .start_addr (cap_start),
        .size_lg    (cap_size),
        .len_lg     (cap_info.len_lg),
        .wrap       (cap_info.wrap),
        .beat_idx   (beat_cnt),
        .exp_addr   (exp_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_IDLE;
        else        state_q <= state_d;
    end

    // capture and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_start <= '0;
            cap_burst <= '0;
            cap_size  <= '0;
            beat_cnt  <= '0;
        end else if (load) begin
            cap_start <= bus_addr;
            cap_burst <= bus_burst;
            cap_size  <= bus_size;
            beat_cnt  <= ONE;
        end else if (adv) begin
            beat_cnt  <= beat_cnt + ONE;
        end
    end

    // next state and beat judgement
    always_comb begin
        state_d = state_q;
        flag    = 1'b0;
        load    = 1'b0;
        adv     = 1'b0;
        if (bus_ready) begin
            unique case (trans_t'(bus_trans))
                TR_NONSEQ: begin
                    load    = 1'b1;
                    state_d = (new_info.fixed && new_info.len_lg == 3'd0)
                              ? MON_END : MON_BURST;
                end
                TR_SEQ: begin
                    if (state_q == MON_BURST) begin
                        adv = 1'b1;
                        if (bus_addr != exp_addr || bus_burst != cap_burst ||
                            bus_size != cap_size)
                            flag = 1'b1;
                        if (cap_info.fixed && beat_cnt == last_idx)
                            state_d = MON_END;
                    end else begin
                        flag = 1'b1;
                    end
                end
                TR_IDLE: state_d = MON_IDLE;
                TR_BUSY: state_d = state_q;
            endcase
        end
    end

    bmon_err_latch #(.AW(AW)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag      (flag),
        .exp_addr  (exp_addr),
        .obs_addr  (bus_addr),
        .pulse     (mismatch_pulse),
        .sticky    (err_sticky),
        .first_exp (first_exp_addr),
        .first_obs (first_obs_addr)
    );
endmodule

// File: rtl/burst_addr_monitor_chk.sv
module burst_addr_monitor_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    bus_trans,
    input logic          bus_ready,
    input logic          mismatch_pulse,
    input logic          err_sticky,
    input logic [AW-1:0] first_exp_addr,
    input logic [AW-1:0] first_obs_addr
);
    p_pulse_sets_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_pulse |-> err_sticky);

    p_sticky_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    p_first_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> ($stable(first_exp_addr) && $stable(first_obs_addr)));

    p_unsampled_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> !mismatch_pulse);

    p_first_beat_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_trans == 2'd2) |=> !mismatch_pulse);

    p_clean_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_sticky |-> (first_exp_addr == '0 && first_obs_addr == '0));
endmodule

bind burst_addr_monitor burst_addr_monitor_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_trans      (bus_trans),
    .bus_ready      (bus_ready),
    .mismatch_pulse (mismatch_pulse),
    .err_sticky     (err_sticky),
    .first_exp_addr (first_exp_addr),
    .first_obs_addr (first_obs_addr)
);

// File: tb/tb_burst_addr_monitor.sv
module tb_burst_addr_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_trans = 2'd0;
    logic [AW-1:0] bus_addr = '0;
    logic [2:0]    bus_burst = 3'd0;
    logic [2:0]    bus_size = 3'd0;
    logic          bus_ready = 1'b1;
    logic          mismatch_pulse, err_sticky;
    logic [AW-1:0] first_exp_addr, first_obs_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_monitor #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_trans(bus_trans), .bus_addr(bus_addr),
        .bus_burst(bus_burst), .bus_size(bus_size), .bus_ready(bus_ready),
        .mismatch_pulse(mismatch_pulse), .err_sticky(err_sticky),
        .first_exp_addr(first_exp_addr), .first_obs_addr(first_obs_addr)
    );

    function automatic int beats_of(input logic [2:0] kind);
        case (kind)
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            3'd6, 3'd7: return 16;
            default:    return 1;
        endcase
    endfunction

    function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] start,
        input logic [2:0] kind, input logic [2:0] sz, input int n);
        logic [AW-1:0] span, lin;
        lin = start + AW'(n * (1 << sz));
        if (kind >= 3'd2 && kind[0] == 1'b0) begin
            span = AW'(beats_of(kind) * (1 << sz));
            return (start & ~(span - 1)) | (lin % span);
        end
        return lin;
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one cycle; returns after the sampling edge, away from it
    task automatic beat(input logic [1:0] tr, input logic [AW-1:0] a,
                        input logic [2:0] kind, input logic [2:0] sz, input logic rdy);
        @(negedge clk);
        bus_trans = tr; bus_addr = a; bus_burst = kind; bus_size = sz; bus_ready = rdy;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_trans = 2'd0; bus_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_legal(input string req, input logic [AW-1:0] start,
                             input logic [2:0] kind, input logic [2:0] sz, input int n);
        beat(2'd2, start, kind, sz, 1'b1);
        check(req, AW'(mismatch_pulse), 0);
        for (int i = 1; i < n; i++) begin
            beat(2'd3, ref_addr(start, kind, sz, i), kind, sz, 1'b1);
            check(req, AW'(mismatch_pulse), 0);
        end
        beat(2'd0, '0, 3'd0, 3'd0, 1'b1);
        check(req, AW'(err_sticky), 0);
    endtask

    task automatic t_reset_r8();
        do_reset();
        #1;
        check("R8 pulse", AW'(mismatch_pulse), 0);
        check("R8 sticky", AW'(err_sticky), 0);
        check("R8 first_exp", first_exp_addr, 0);
        check("R8 first_obs", first_obs_addr, 0);
    endtask

    task automatic t_linear_r1();
        do_reset();
        run_legal("R1 incr4", 32'h1000, 3'd3, 3'd2, 4);
        run_legal("R1 open-ended across 0x400", 32'h3F8, 3'd1, 3'd2, 6);
        run_legal("R1 incr8 halfword", 32'h1FA, 3'd5, 3'd1, 8);
    endtask

    task automatic t_wrap_r2();
        do_reset();
        check("R2 ref 0x3038 beat2", ref_addr(32'h3038, 3'd6, 3'd2, 2), 32'h3000);
        run_legal("R2 wrap4 words", 32'h1008, 3'd2, 3'd2, 4);
        run_legal("R2 wrap16 words", 32'h3038, 3'd6, 3'd2, 16);
        run_legal("R2 wrap8 bytes", 32'h25, 3'd4, 3'd0, 8);
        run_legal("R2 wrap4 dwords", 32'h118, 3'd2, 3'd3, 4);
    endtask

    task automatic t_no_wrap_r3();
        do_reset();
        beat(2'd2, 32'h1008, 3'd2, 3'd2, 1'b1);
        beat(2'd3, 32'h100C, 3'd2, 3'd2, 1'b1);
        check("R3 legal beat", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h1010, 3'd2, 3'd2, 1'b1);
        check("R3 run past block", AW'(mismatch_pulse), 1);
        check("R7 sticky", AW'(err_sticky), 1);
        check("R7 first_exp", first_exp_addr, 32'h1000);
        check("R7 first_obs", first_obs_addr, 32'h1010);
        beat(2'd3, 32'h1004, 3'd2, 3'd2, 1'b1);
        check("R3 one cycle", AW'(mismatch_pulse), 0);
        check("R7 sticky held", AW'(err_sticky), 1);
    endtask

    task automatic t_bad_base_r3();
        do_reset();
        beat(2'd2, 32'h2010, 3'd4, 3'd2, 1'b1);
        beat(2'd3, 32'h2014, 3'd4, 3'd2, 1'b1);
        beat(2'd3, 32'h2018, 3'd4, 3'd2, 1'b1);
        beat(2'd3, 32'h201C, 3'd4, 3'd2, 1'b1);
        check("R3 before wrap", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h2010, 3'd4, 3'd2, 1'b1);
        check("R3 wrong base", AW'(mismatch_pulse), 1);
        check("R7 first_exp", first_exp_addr, 32'h2000);
        check("R7 first_obs", first_obs_addr, 32'h2010);
        beat(2'd3, 32'h2014, 3'd4, 3'd2, 1'b1);
        check("R7 second mismatch pulses", AW'(mismatch_pulse), 1);
        check("R7 first_exp kept", first_exp_addr, 32'h2000);
        check("R7 first_obs kept", first_obs_addr, 32'h2010);
    endtask

    task automatic t_ready_busy_r4();
        do_reset();
        beat(2'd2, 32'h1008, 3'd2, 3'd2, 1'b1);
        beat(2'd1, 32'hDEAD, 3'd2, 3'd2, 1'b1);
        check("R4 busy", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'hFFF0, 3'd7, 3'd0, 1'b0);
        check("R4 ready low", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h100C, 3'd2, 3'd2, 1'b1);
        check("R4 count held", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h1000, 3'd2, 3'd2, 1'b1);
        beat(2'd3, 32'h1004, 3'd2, 3'd2, 1'b1);
        check("R4 burst end", AW'(err_sticky), 0);
        do_reset();
        beat(2'd2, 32'h500, 3'd1, 3'd2, 1'b1);
        beat(2'd0, 32'h0, 3'd1, 3'd2, 1'b1);
        beat(2'd3, 32'h504, 3'd1, 3'd2, 1'b1);
        check("R4 idle closes burst", AW'(mismatch_pulse), 1);
    endtask

    task automatic t_attr_r5();
        do_reset();
        beat(2'd2, 32'h100, 3'd5, 3'd1, 1'b1);
        beat(2'd3, 32'h102, 3'd5, 3'd1, 1'b1);
        check("R5 legal", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h104, 3'd5, 3'd2, 1'b1);
        check("R5 size change", AW'(mismatch_pulse), 1);
        do_reset();
        beat(2'd2, 32'h1008, 3'd2, 3'd2, 1'b1);
        beat(2'd3, 32'h100C, 3'd3, 3'd2, 1'b1);
        check("R5 kind change", AW'(mismatch_pulse), 1);
    endtask

    task automatic t_length_r6();
        do_reset();
        beat(2'd3, 32'h0, 3'd1, 3'd2, 1'b1);
        check("R6 no open burst", AW'(mismatch_pulse), 1);
        do_reset();
        beat(2'd2, 32'h40, 3'd3, 3'd2, 1'b1);
        for (int i = 1; i < 4; i++) beat(2'd3, 32'h40 + AW'(4 * i), 3'd3, 3'd2, 1'b1);
        check("R6 last beat legal", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h50, 3'd3, 3'd2, 1'b1);
        check("R6 beat past incr4", AW'(mismatch_pulse), 1);
        do_reset();
        beat(2'd2, 32'h80, 3'd0, 3'd2, 1'b1);
        check("R6 single ok", AW'(mismatch_pulse), 0);
        beat(2'd3, 32'h84, 3'd0, 3'd2, 1'b1);
        check("R6 beat after single", AW'(mismatch_pulse), 1);
    endtask

    initial begin
        t_reset_r8();
        t_linear_r1();
        t_wrap_r2();
        t_no_wrap_r3();
        t_bad_base_r3();
        t_ready_busy_r4();
        t_attr_r5();
        t_length_r6();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule